// File: doc/BRIEF.md
# Oscilloscope Sweep Gate Controller

This block makes the gate that starts and stops the timebase ramp of a sampling display. An idle, armed controller opens the gate on a trigger pulse. The ramp is modelled as an internal counter that runs while the gate is open. When the counter reaches a programmable terminal value, an end-of-sweep condition closes the gate. A one-cycle sweep-reset strobe marks that event and loads a holdoff timer. While the timer runs, the gate is held shut and triggers are dropped. Once it expires, the next trigger starts a new sweep.

The mode input selects normal or auto triggering. In auto mode, an external force-start request opens the gate whenever the controller is armed. An auto-baseline timer outside this block raises that request when no trigger has arrived for some time. In normal mode the request has no effect. End-of-sweep and the running holdoff together form one reset-hold term, and that term beats any start request in the same cycle.

Top module: `sweep_gate_ctrl`

## Requirements
- R1: When the gate is low and holdoff_o is low, a high trig_i in a cycle makes gate_o high after the next clock edge.
- R2: While gate_o is high, ramp_o counts up by one per cycle from 0. gate_o stays high for ramp_term_i + 1 cycles and goes low in the cycle after ramp_o equals ramp_term_i.
- R3: A trigger or force-start request that arrives while the gate is high, including the end-of-sweep cycle, does not extend or restart the sweep.
- R4: sweep_rst_o is high for exactly one cycle per sweep: the first cycle in which gate_o is low again.
- R5: holdoff_o goes high together with sweep_rst_o and stays high for exactly L cycles, where L is the holdoff_len_i value sampled in the end-of-sweep cycle.
- R6: Triggers are ignored while holdoff_o is high (gate_o stays low). A trigger in the first cycle after holdoff_o falls starts a sweep.
- R7: With L = 0, holdoff_o stays low, and a trigger in the sweep_rst_o cycle starts the next sweep.
- R8: With mode_i = 1 (auto), a high force_start_i while the gate is low and holdoff_o is low makes gate_o high after the next edge. A force-start during holdoff is ignored.
- R9: With mode_i = 0 (normal), force_start_i has no effect on gate_o.
- R10: ramp_o is 0 in every cycle that follows a cycle with gate_o low.
- R11: After reset, gate_o, sweep_rst_o, holdoff_o and ramp_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Synchronous trigger pulse |
| force_start_i | input | 1 | Start request from the auto-baseline unit |
| mode_i | input | 1 | 0 = normal, 1 = auto |
| ramp_term_i | input | RAMP_W | Terminal count of the modelled ramp |
| holdoff_len_i | input | HO_W | Holdoff length in clock cycles, 0 = none |
| gate_o | output | 1 | Sweep gate |
| sweep_rst_o | output | 1 | One-cycle end-of-sweep strobe |
| holdoff_o | output | 1 | Holdoff in progress |
| ramp_o | output | RAMP_W | Modelled ramp value |

## Verification
The bench builds the controller with RAMP_W = 4 and HO_W = 4. With these widths the largest terminal count (15) and the longest holdoff (15 cycles) can be reached in a few dozen cycles, so the full-scale boundaries are tested alongside a terminal count of 0 and a holdoff of 0. A vector table with terminal count 3 and holdoff 2 walks through trigger collisions with end-of-sweep and holdoff, and through force-start in both modes.

// File: rtl/sweep_gate_pkg.sv
package sweep_gate_pkg;

   typedef enum logic {
      SG_MODE_NORMAL = 1'b0,
      SG_MODE_AUTO   = 1'b1
   } sg_mode_e;

   typedef enum logic {
      SG_TRIG_PULSE = 1'b0,
      SG_TRIG_EDGE  = 1'b1
   } sg_trig_e;

endpackage

// File: rtl/sgc_ramp.sv
module sgc_ramp #(
   parameter int RAMP_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gate_i,
   input  logic [RAMP_W-1:0] term_i,
   output logic [RAMP_W-1:0] ramp_o,
   output logic              eos_o
);

   localparam logic [RAMP_W-1:0] STEP = RAMP_W'(1);

   logic [RAMP_W-1:0] cnt_q;
   logic              at_term;

   if (RAMP_W < 1) begin : g_bad_w
      $error("sgc_ramp: RAMP_W must be at least 1");
   end

   assign at_term = (cnt_q == term_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!gate_i) begin
         cnt_q <= '0;
      end else if (!at_term) begin
         cnt_q <= cnt_q + STEP;
      end
   end

   assign ramp_o = cnt_q;
   assign eos_o  = gate_i & at_term;

endmodule

// File: rtl/sgc_holdoff.sv
module sgc_holdoff #(
   parameter int HO_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fire_i,
   input  logic [HO_W-1:0] len_i,
   output logic            active_o
);

   localparam logic [HO_W-1:0] ONE = HO_W'(1);

   logic [HO_W-1:0] left_q;

   if (HO_W < 1) begin : g_bad_w
      $error("sgc_holdoff: HO_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (fire_i) begin
         left_q <= len_i;
      end else if (left_q != '0) begin
         left_q <= left_q - ONE;
      end
   end

   assign active_o = (left_q != '0);

endmodule

// File: rtl/sgc_gate.sv
module sgc_gate
   import sweep_gate_pkg::*;
#(
   parameter sg_trig_e TRIG_KIND = SG_TRIG_PULSE
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     trig_i,
   input  logic     force_i,
   input  sg_mode_e mode_i,
   input  logic     hold_i,
   output logic     gate_o
);

   logic trig_eff;
   logic start_req;
   logic gate_q;

   if (TRIG_KIND == SG_TRIG_EDGE) begin : g_edge
      logic trig_prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) trig_prev_q <= 1'b0;
         else        trig_prev_q <= trig_i;
      end
      assign trig_eff = trig_i & ~trig_prev_q;
   end else begin : g_pulse
      assign trig_eff = trig_i;
   end

   assign start_req = trig_eff | ((mode_i == SG_MODE_AUTO) & force_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q <= 1'b0;
      end else if (hold_i) begin
         gate_q <= 1'b0;
      end else if (!gate_q && start_req) begin
         gate_q <= 1'b1;
      end
   end

   assign gate_o = gate_q;

endmodule

// File: rtl/sweep_gate_ctrl.sv
module sweep_gate_ctrl
   import sweep_gate_pkg::*;
#(
   parameter int       RAMP_W    = 16,
   parameter int       HO_W      = 16,
   parameter sg_trig_e TRIG_KIND = SG_TRIG_PULSE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_i,
   input  logic              force_start_i,
   input  logic              mode_i,
   input  logic [RAMP_W-1:0] ramp_term_i,
   input  logic [HO_W-1:0]   holdoff_len_i,
   output logic              gate_o,
   output logic              sweep_rst_o,
   output logic              holdoff_o,
   output logic [RAMP_W-1:0] ramp_o
);

   logic     gate;
   logic     eos;
   logic     ho_active;
   logic     reset_hold;
   logic     strobe_q;
   sg_mode_e mode;

   assign mode       = sg_mode_e'(mode_i);
   assign reset_hold = eos | ho_active;

   sgc_gate #(
      .TRIG_KIND(TRIG_KIND)
   ) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig_i (trig_i),
      .force_i(force_start_i),
      .mode_i (mode),
      .hold_i (reset_hold),
      .gate_o (gate)
   );

   sgc_ramp #(
      .RAMP_W(RAMP_W)
   ) u_ramp (
      .clk   (clk),
      .rst_n (rst_n),
      .gate_i(gate),
      .term_i(ramp_term_i),
      .ramp_o(ramp_o),
      .eos_o (eos)
   );

   sgc_holdoff #(
      .HO_W(HO_W)
   ) u_holdoff (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire_i  (eos),
      .len_i   (holdoff_len_i),
      .active_o(ho_active)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_q <= 1'b0;
      else        strobe_q <= eos;
   end

   assign gate_o      = gate;
   assign sweep_rst_o = strobe_q;
   assign holdoff_o   = ho_active;

endmodule

// File: rtl/sgc_checker.sv
module sgc_checker #(
   parameter int RAMP_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              trig_i,
   input logic              force_start_i,
   input logic              mode_i,
   input logic              gate_o,
   input logic              sweep_rst_o,
   input logic              holdoff_o,
   input logic [RAMP_W-1:0] ramp_o
);

   // R4: the strobe never lasts two cycles
   p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_rst_o |=> !sweep_rst_o);

   // R4: the strobe marks a closed gate
   p_strobe_gate_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_rst_o |-> !gate_o);

   // R6: no sweep opens out of a holdoff cycle
   p_holdoff_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      holdoff_o |=> !gate_o);

   // R1: armed trigger opens the gate
   p_trig_starts_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_o && !holdoff_o && trig_i) |=> gate_o);

   // R8: auto force-start opens the gate when armed
   p_force_auto_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_o && !holdoff_o && mode_i && force_start_i) |=> gate_o);

   // R9: normal mode without trigger keeps the gate shut
   p_force_normal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_o && !mode_i && !trig_i) |=> !gate_o);

   // R10: ramp clears behind a closed gate
   p_ramp_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_o |=> (ramp_o == '0));

endmodule

bind sweep_gate_ctrl sgc_checker #(
   .RAMP_W(RAMP_W)
) i_sgc_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .trig_i       (trig_i),
   .force_start_i(force_start_i),
   .mode_i       (mode_i),
   .gate_o       (gate_o),
   .sweep_rst_o  (sweep_rst_o),
   .holdoff_o    (holdoff_o),
   .ramp_o       (ramp_o)
);

// File: tb/test_sweep_gate_ctrl.sv
`timescale 1ns/1ps
module test_sweep_gate_ctrl;

   localparam int RW = 4;
   localparam int HW = 4;
   localparam int NV = 18;

   // {trig, force, auto, exp_gate, exp_rst, exp_ho, exp_ramp[3:0]}
   localparam logic [9:0] VEC [NV] = '{
      10'b000_000_0000, 10'b100_100_0000, 10'b000_100_0001,
      10'b100_100_0010, 10'b000_100_0011, 10'b100_011_0011,
      10'b100_001_0000, 10'b100_000_0000, 10'b100_100_0000,
      10'b010_100_0001, 10'b000_100_0010, 10'b000_100_0011,
      10'b000_011_0011, 10'b011_001_0000, 10'b011_000_0000,
      10'b010_000_0000, 10'b011_100_0000, 10'b000_100_0001
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          trig_i = 1'b0;
   logic          force_start_i = 1'b0;
   logic          mode_i = 1'b0;
   logic [RW-1:0] ramp_term_i = '0;
   logic [HW-1:0] holdoff_len_i = '0;
   logic          gate_o, sweep_rst_o, holdoff_o;
   logic [RW-1:0] ramp_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   sweep_gate_ctrl #(.RAMP_W(RW), .HO_W(HW)) i_sweep_gate_ctrl (
      .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .force_start_i(force_start_i),
      .mode_i(mode_i), .ramp_term_i(ramp_term_i), .holdoff_len_i(holdoff_len_i),
      .gate_o(gate_o), .sweep_rst_o(sweep_rst_o), .holdoff_o(holdoff_o),
      .ramp_o(ramp_o));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drive inputs, take one edge, then observe
   task automatic step(input logic t, input logic f, input logic m);
      trig_i = t; force_start_i = f; mode_i = m;
      @(posedge clk); #1;
   endtask

   task automatic do_reset();
      trig_i = 0; force_start_i = 0; mode_i = 0;
      rst_n = 0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1;
   endtask

   initial begin
      #1;
      do_reset();
      // R11 reset state
      chk("R11 gate", gate_o, 0);
      chk("R11 strobe", sweep_rst_o, 0);
      chk("R11 holdoff", holdoff_o, 0);
      chk("R11 ramp", ramp_o, 0);

      // table: term 3, holdoff 2 (R1 R2 R3 R4 R5 R6 R8 R9 R10)
      ramp_term_i = 4'd3; holdoff_len_i = 4'd2;
      for (int i = 0; i < NV; i++) begin
         step(VEC[i][9], VEC[i][8], VEC[i][7]);
         chk($sformatf("R1/R2/R3 gate row %0d", i), gate_o, VEC[i][6]);
         chk($sformatf("R4 strobe row %0d", i), sweep_rst_o, VEC[i][5]);
         chk($sformatf("R5/R6/R8/R9 holdoff row %0d", i), holdoff_o, VEC[i][4]);
         chk($sformatf("R2/R10 ramp row %0d", i), ramp_o, VEC[i][3:0]);
      end

      // R7: zero holdoff, terminal count 0
      do_reset();
      ramp_term_i = 4'd0; holdoff_len_i = 4'd0;
      step(1, 0, 0);
      chk("R2 term0 gate open", gate_o, 1);
      step(0, 0, 0);
      chk("R2 term0 one-cycle gate", gate_o, 0);
      chk("R4 term0 strobe", sweep_rst_o, 1);
      chk("R7 no holdoff", holdoff_o, 0);
      step(1, 0, 0);
      chk("R7 immediate rearm", gate_o, 1);

      // R2/R5 full-scale: term 15, holdoff 15
      do_reset();
      ramp_term_i = 4'd15; holdoff_len_i = 4'd15;
      step(1, 0, 0);
      begin
         int hi = 0;
         while (gate_o && hi < 40) begin hi++; step(0, 0, 0); end
         chk("R2 gate length at term 15", hi, 16);
      end
      chk("R4 strobe at max", sweep_rst_o, 1);
      holdoff_len_i = 4'd3; // changed after sampling, must not matter
      begin
         int ho = 0;
         while (holdoff_o && ho < 40) begin ho++; step(1, 0, 0); chk("R6 trigger ignored in holdoff", gate_o, 0); end
         chk("R5 holdoff length 15", ho, 15);
      end
      step(1, 0, 0);
      chk("R6 trigger after holdoff", gate_o, 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule